// File: doc/BRIEF.md
# PHY Status LED Controller

This block turns the live status of a 10/100 Ethernet physical layer into five LED drive levels. The indicators are 10 Mbps speed, 100 Mbps speed, receive activity, link, and full-duplex/collision. The status inputs are speed, duplex, link-good, transmit activity, receive activity and collision. They are sampled on the system clock, and the LED levels are registered once, so every output is glitch free.

Five strap pins have two jobs. While reset is held, each strap level sets whether the LED of the same index is driven active high or active low. Together, the five straps also form the PHY management address. The values in force when reset is released are kept until the next reset. An address of zero raises an isolate flag.

Blinking is timed from the system clock. A prescaler of `CLK_DIV` clocks produces a base tick. The collision indicator toggles on every tick. The activity and link indicators toggle on every second tick. At the default `CLK_DIV`, a 50 MHz clock gives 40 ticks per second, which makes the collision blink 20 Hz and the activity blink 10 Hz.

Top module: `phy_led_ctrl`

## Requirements
- R1: LED index 0 is lit when `speed_100_i` is low, and LED index 1 is lit when it is high. Exactly one of the two is lit at any time outside reset.
- R2: LED index 2 (activity) is lit only when the link is up, `rx_act_i` is high, `col_i` is low and the slow blink phase is on. In all other cases it is dark.
- R3: LED index 3 (link) is lit steadily while the link is up and both activity inputs are low. While the link is up and either activity input is high, it follows the slow blink phase.
- R4: LED index 4 is lit steadily when full duplex is set and there is no collision. While `col_i` is high, it follows the fast blink phase. Otherwise it is dark.
- R5: For each LED i, a strap i sampled low gives an output where 1 means lit. A strap i sampled high gives an output where 0 means lit.
- R6: `phy_addr_o` equals the strap pins sampled at reset, with strap i as address bit i.
- R7: `isolate_o` is high exactly when the sampled address is 00000.
- R8: Strap values are captured on every clock while reset is held, and are frozen from reset release onward. Strap changes after release have no effect on polarity, address or isolate.
- R9: While the link is down, the activity and link LEDs are dark, whatever the activity inputs are.
- R10: Let e be the number of clock edges since reset release, counting from 0. Then the blink phase is p = (e / CLK_DIV) mod 4. Fast blink is bit 0 of p, and slow blink is bit 1 of p.
- R11: While reset is held, every LED output sits at its off level, which is the strap value.
- R12: Every LED output reflects the status inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| strap_i | input | 5 | Address/polarity strap pins |
| speed_100_i | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_duplex_i | input | 1 | Full-duplex mode |
| link_up_i | input | 1 | Good link detected |
| tx_act_i | input | 1 | Transmit activity |
| rx_act_i | input | 1 | Receive activity |
| col_i | input | 1 | Collision |
| led_o | output | 5 | LED drive levels: 0 10M, 1 100M, 2 activity, 3 link, 4 duplex/collision |
| phy_addr_o | output | 5 | Sampled PHY address |
| isolate_o | output | 1 | Sampled address is zero |

## Verification
Each LED level is due one clock edge after the status it depends on. Blink phase changes are due on the edge that follows the prescaler wrap. The address and isolate outputs are due on the first clock edge while reset is held, and they never move after release. The bench holds a behavioural model that counts edges since release and computes each LED from the inputs that were stable at that edge. It compares all outputs a quarter period after every rising edge, which is well before the next input change at the falling edge.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
   localparam int NUM_LED = 5;
   localparam int IDX_10M  = 0;
   localparam int IDX_100M = 1;
   localparam int IDX_ACT  = 2;
   localparam int IDX_LINK = 3;
   localparam int IDX_FDX  = 4;

   typedef struct packed {
      logic speed_100;
      logic full_duplex;
      logic link_up;
      logic tx_act;
      logic rx_act;
      logic col;
   } phy_stat_t;
endpackage

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
   parameter int CLK_DIV = 1250000
) (
   input  logic clk,
   input  logic rst_n,
   output logic blink_fast,
   output logic blink_slow
);
   logic       tick;
   logic [1:0] phase_q;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("led_blink_timer: CLK_DIV must be at least 1");
      end

      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CNT_W = $clog2(CLK_DIV);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)            cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == LAST);

         assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    phase_q <= '0;
      else if (tick) phase_q <= phase_q + 1'b1;
   end

   assign blink_fast = phase_q[0];
   assign blink_slow = phase_q[1];

   assert_phase_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(tick)) |-> $stable(phase_q));
endmodule

// File: rtl/led_strap_latch.sv
module led_strap_latch #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] strap_i,
   output logic [ADDR_W-1:0] strap_q,
   output logic              isolate_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_i;
   end

   assign isolate_o = ~|strap_q;

   assert_strap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/led_pattern.sv
module led_pattern
   import phy_led_pkg::*;
#(
   parameter int N = NUM_LED
) (
   input  logic         clk,
   input  logic         rst_n,
   input  phy_stat_t    stat_i,
   input  logic         blink_fast,
   input  logic         blink_slow,
   input  logic [N-1:0] polarity_i,
   output logic [N-1:0] led_o
);
   logic [N-1:0] on_d, on_q;
   logic         busy;

   assign busy = stat_i.tx_act | stat_i.rx_act;

   always_comb begin
      on_d           = '0;
      on_d[IDX_10M]  = ~stat_i.speed_100;
      on_d[IDX_100M] = stat_i.speed_100;
      on_d[IDX_ACT]  = stat_i.link_up & stat_i.rx_act & ~stat_i.col & blink_slow;
      on_d[IDX_LINK] = stat_i.link_up & (busy ? blink_slow : 1'b1);
      on_d[IDX_FDX]  = stat_i.col ? blink_fast : stat_i.full_duplex;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) on_q <= '0;
      else        on_q <= on_d;
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_drv
         assign led_o[i] = on_q[i] ^ polarity_i[i];
      end
   endgenerate

   assert_speed_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (on_q[IDX_10M] != on_q[IDX_100M]));
   assert_act_nocol_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(stat_i.col)) |-> !on_q[IDX_ACT]);
   assert_fdx_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(stat_i.full_duplex) && !$past(stat_i.col)) |-> on_q[IDX_FDX]);
   assert_linkdown_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(stat_i.link_up)) |-> (!on_q[IDX_ACT] && !on_q[IDX_LINK]));
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
   import phy_led_pkg::*;
#(
   parameter int CLK_DIV = 1250000,
   parameter int ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] strap_i,
   input  logic              speed_100_i,
   input  logic              full_duplex_i,
   input  logic              link_up_i,
   input  logic              tx_act_i,
   input  logic              rx_act_i,
   input  logic              col_i,
   output logic [ADDR_W-1:0] led_o,
   output logic [ADDR_W-1:0] phy_addr_o,
   output logic              isolate_o
);
   generate
      if (ADDR_W != NUM_LED) begin : g_bad_w
         $error("phy_led_ctrl: one strap per LED is required");
      end
   endgenerate

   phy_stat_t         stat;
   logic              fast, slow;
   logic [ADDR_W-1:0] strap_q;

   assign stat.speed_100   = speed_100_i;
   assign stat.full_duplex = full_duplex_i;
   assign stat.link_up     = link_up_i;
   assign stat.tx_act      = tx_act_i;
   assign stat.rx_act      = rx_act_i;
   assign stat.col         = col_i;

   led_blink_timer #(.CLK_DIV(CLK_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .blink_fast(fast), .blink_slow(slow));

   led_strap_latch #(.ADDR_W(ADDR_W)) u_strap (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
      .strap_q(strap_q), .isolate_o(isolate_o));

   led_pattern #(.N(ADDR_W)) u_pat (
      .clk(clk), .rst_n(rst_n), .stat_i(stat),
      .blink_fast(fast), .blink_slow(slow),
      .polarity_i(strap_q), .led_o(led_o));

   assign phy_addr_o = strap_q;

   assert_isolate_addr_R7: assert property (@(posedge clk)
      isolate_o |-> (phy_addr_o == '0));
   assert_reset_off_R11: assert property (@(posedge clk)
      (!rst_n && !$isunknown(strap_i)) |=> (!$past(rst_n) |-> (led_o == phy_addr_o)));
endmodule

// File: tb/tb_phy_led_ctrl.sv
module tb_phy_led_ctrl;
   localparam int DIV = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] strap_i = 5'b00000;
   logic       speed_100_i = 0, full_duplex_i = 0, link_up_i = 0;
   logic       tx_act_i = 0, rx_act_i = 0, col_i = 0;
   logic [4:0] led_o, phy_addr_o;
   logic       isolate_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   phy_led_ctrl #(.CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
      .speed_100_i(speed_100_i), .full_duplex_i(full_duplex_i),
      .link_up_i(link_up_i), .tx_act_i(tx_act_i), .rx_act_i(rx_act_i),
      .col_i(col_i), .led_o(led_o), .phy_addr_o(phy_addr_o),
      .isolate_o(isolate_o));

   // reference model
   logic [4:0] m_strap = 5'b0;
   logic [4:0] m_on = 5'b0;
   int         m_edges = 0;
   bit         model_ok = 0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_strap = strap_i;
         m_on = 5'b0;
         m_edges = 0;
         model_ok = 1;
      end else begin
         int ph;
         bit f, s;
         ph = (m_edges / DIV) % 4;
         f = (ph % 2) == 1;
         s = (ph / 2) == 1;
         m_on[0] = !speed_100_i;
         m_on[1] = speed_100_i;
         m_on[2] = link_up_i && rx_act_i && !col_i && s;
         m_on[3] = link_up_i && ((tx_act_i || rx_act_i) ? s : 1'b1);
         m_on[4] = col_i ? f : full_duplex_i;
         m_edges++;
      end
   end

   function automatic string led_req(int i);
      case (i)
         0, 1:    return "R1 R12";
         2:       return "R2 R9 R10";
         3:       return "R3 R9 R10";
         default: return "R4 R10";
      endcase
   endfunction

   task automatic check(bit ok, string req, int got, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got %0h exp %0h", req, got, exp);
      end
   endtask

   // per-cycle comparison, a quarter period after each rising edge
   always @(posedge clk) begin
      #5;
      if (model_ok) begin
         for (int i = 0; i < 5; i++) begin
            logic e;
            e = rst_n ? (m_on[i] ^ m_strap[i]) : m_strap[i]; // R5 polarity, R11 reset level
            check(led_o[i] === e, rst_n ? led_req(i) : "R11", int'(led_o[i]), int'(e));
         end
         check(phy_addr_o === m_strap, "R6 R8", int'(phy_addr_o), int'(m_strap));
         check(isolate_o === (m_strap == 5'b0), "R7", int'(isolate_o), int'(m_strap == 5'b0));
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(logic [4:0] s);
      @(negedge clk);
      rst_n = 1'b0;
      strap_i = s;
      run(3);
      rst_n = 1'b1;
      strap_i = ~s;   // R8: later strap changes must be ignored
   endtask

   task automatic scenario();
      speed_100_i = 0; link_up_i = 0; rx_act_i = 1; tx_act_i = 1;
      run(20);                                  // R9 link down, activity present
      link_up_i = 1; rx_act_i = 0; tx_act_i = 0;
      run(10);                                  // R3 steady link
      speed_100_i = 1; run(2);                  // R1 R12
      rx_act_i = 1; run(40);                    // R2 R3 R10 blinking
      rx_act_i = 0; tx_act_i = 1; run(20);      // R3 blink on transmit only
      col_i = 1; rx_act_i = 1; run(40);         // R2 suppressed, R4 fast blink
      col_i = 0; full_duplex_i = 1; run(10);    // R4 steady
      link_up_i = 0; run(10);                   // R9
      speed_100_i = 0; full_duplex_i = 0; tx_act_i = 0; rx_act_i = 0;
      run(5);
   endtask

   initial begin
      do_reset(5'b00000);   // R7 isolate, active-high outputs
      scenario();
      do_reset(5'b10110);   // R5 mixed polarity
      // explicit R5: LED 1 (100M) active low, LED 0 active high
      speed_100_i = 1; run(2);
      check(led_o[1] === 1'b0 && led_o[0] === 1'b0, "R5", int'(led_o[1:0]), 0);
      check(phy_addr_o === 5'b10110, "R8", int'(phy_addr_o), 5'b10110);
      scenario();
      do_reset(5'b11111);   // R5 all active low
      scenario();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // watchdog
   always @(posedge clk) begin
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired got %0d exp 0", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule